// File: doc/BRIEF.md
# Streaming Matrix-Vector Multiplier

This block takes in a 64-row by 8-column matrix of unsigned bytes, followed by an 8-element byte vector, over a 32-bit input stream that uses a valid/ready handshake. It multiplies the matrix by the vector and sends the 64 dot products back on a 32-bit output stream. The last output beat is marked as the end of the packet.

A processor-side FIFO or DMA engine feeds the block. The frame length is fixed by counting words, so the frame can arrive in a single burst or in several bursts with idle time between them. Either side of the block may stall at any point. The block holds the matrix, the vector and all 64 results in internal storage. It takes the frame in, then computes one row per cycle, then drains the results. After that it is ready for the next frame.

Top module: `mxv_stream`

## Requirements
- R1: After the active-low synchronous reset, in_ready is 1 and both out_valid and out_last are 0.
- R2: A word is consumed only on a rising edge where in_valid and in_ready are both 1. Gaps in in_valid of any length cause no word to be lost or repeated.
- R3: Input words come in this order: matrix row 0 columns 0..7, then row 1, through row 63, then vector elements 0..7. Only bits [7:0] of each word carry the element value. Bits [31:8] have no effect on any result.
- R4: Result i equals the sum over k=0..7 of A[i][k]*B[k]. It is zero-extended to 32 bits, so all-255 inputs give 520200.
- R5: in_ready stays 0 from the acceptance of the 520th word until the final result has been accepted. It is never 1 while out_valid is 1.
- R6: Each frame produces exactly 64 output beats, in row order 0 to 63.
- R7: out_last is 1 only on the beat that carries result 63, and only while out_valid is 1.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R9: in_last has no effect. The frame ends after exactly 520 accepted words, whatever in_last does.
- R10: In the cycle after the final beat is accepted, in_ready is 1 again and the next frame is processed correctly.
- R11: A frame split into two bursts with a long idle period between them gives the same results as a continuous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Input stream word, element in bits [7:0] |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept an input word |
| in_last | input | 1 | Input end-of-packet marker, ignored |
| out_data | output | 32 | Result word |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Downstream can accept a result |
| out_last | output | 1 | Marks the final result of the frame |

## Verification
The assertions check on every cycle that out_last appears only with out_valid and only on the 64th beat, that a stalled output holds its value, that the input and output sides are never open at once, and that the input reopens right after the final beat. The arithmetic cannot be checked by these properties: the word order, the masking of the upper bits and the dot-product values. The bench shows these in its scenarios. It compares every beat against products computed independently for all-maximum, all-zero, random and garbage-padded frames. It also shows the tolerance to gaps, random backpressure, a two-burst frame and a toggling in_last.

// File: rtl/mxv_stream.sv
module mxv_stream #(
  parameter int ROWS = 64,
  parameter int COLS = 8,
  parameter int EW   = 8,
  parameter int DW   = 32
) (
  input  logic          aclk,
  input  logic          aresetn,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_last,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_last
);
  localparam int NA  = ROWS * COLS;
  localparam int NW  = NA + COLS;
  localparam int CW  = $clog2(NW + 1);
  localparam int AIW = $clog2(NA);
  localparam int BIW = $clog2(COLS);
  localparam int RW  = $clog2(ROWS);
  localparam int AW  = 2 * EW + BIW;

  typedef enum logic [1:0] {RECV, CALC, SEND} st_t;

  st_t             st;
  logic [CW-1:0]   wcnt;
  logic [RW-1:0]   row;
  logic [EW-1:0]   amem [NA];
  logic [EW-1:0]   bmem [COLS];
  logic [AW-1:0]   rmem [ROWS];
  logic [AW-1:0]   dot;
  logic [CW-1:0]   bofs;

  wire take = in_valid && in_ready;
  wire give = out_valid && out_ready;
  wire last_row = row == RW'(ROWS - 1);

  assign in_ready  = st == RECV;
  assign out_valid = st == SEND;
  assign out_last  = out_valid && last_row;
  assign out_data  = DW'(rmem[row]);
  assign bofs      = wcnt - CW'(NA);

  always_comb begin
    dot = '0;
    for (int k = 0; k < COLS; k++)
      dot = dot + AW'(amem[AIW'(row) * AIW'(COLS) + AIW'(k)]) * AW'(bmem[k]);
  end

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      st   <= RECV;
      wcnt <= '0;
      row  <= '0;
    end else begin
      case (st)
        RECV: if (take) begin
          if (wcnt == CW'(NW - 1)) begin
            wcnt <= '0;
            row  <= '0;
            st   <= CALC;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        CALC: begin
          row <= last_row ? '0 : row + 1'b1;
          if (last_row) st <= SEND;
        end
        SEND: if (give) begin
          row <= last_row ? '0 : row + 1'b1;
          if (last_row) st <= RECV;
        end
        default: st <= RECV;
      endcase
    end
  end

  always_ff @(posedge aclk) begin
    if (take) begin
      if (wcnt < CW'(NA)) amem[AIW'(wcnt)] <= in_data[EW-1:0];
      else                bmem[BIW'(bofs)] <= in_data[EW-1:0];
    end
    if (st == CALC) rmem[row] <= dot;
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, in_last, in_data[DW-1:EW]};
endmodule

// File: rtl/mxv_stream_chk.sv
module mxv_stream_chk #(
  parameter int ROWS = 64,
  parameter int DW   = 32
) (
  input logic          aclk,
  input logic          aresetn,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_last,
  input logic [DW-1:0] out_data
);
  localparam int RW = $clog2(ROWS);
  logic [RW-1:0] beats;

  always_ff @(posedge aclk) begin
    if (!aresetn) beats <= '0;
    else if (out_valid && out_ready) beats <= out_last ? '0 : beats + 1'b1;
  end

  // R7
  last_needs_valid_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    out_last |-> out_valid);

  // R6
  last_on_final_beat_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    out_valid |-> (out_last == (beats == RW'(ROWS - 1))));

  // R8
  stall_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R5
  one_side_open_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    !(out_valid && in_ready));

  // R10
  reopen_after_last_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);
endmodule

bind mxv_stream mxv_stream_chk #(.ROWS(ROWS), .DW(DW)) chk (
  .aclk(aclk), .aresetn(aresetn), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data));

// File: tb/mxv_stream_test.sv
module mxv_stream_test;
  localparam int ROWS = 64, COLS = 8, NA = ROWS * COLS;

  logic        aclk = 0, aresetn = 0;
  logic [31:0] in_data = '0, out_data;
  logic        in_valid = 0, in_ready, in_last = 0;
  logic        out_valid, out_ready = 0, out_last;

  int compared = 0, mismatched = 0;
  int unsigned a [NA];
  int unsigned b [COLS];
  logic [31:0] words [NA + COLS];

  mxv_stream uut (.*);

  always #10 aclk = ~aclk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge aclk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // mode 0 all max, 1 random with junk upper bits, 2 zeros, 3 small random
  task automatic make_frame(int mode);
    for (int i = 0; i < NA + COLS; i++) begin
      int unsigned e;
      logic [23:0] junk;
      case (mode)
        0: e = 255;
        1: e = $urandom_range(0, 255);
        2: e = 0;
        default: e = $urandom_range(0, 3);
      endcase
      junk = (mode == 1) ? 24'($urandom) : 24'h0;
      if (i < NA) a[i] = e; else b[i - NA] = e;
      words[i] = {junk, 8'(e)};
    end
  endtask

  task automatic put_word(logic [31:0] w, int gap);
    for (int g = 0; g < gap; g++) begin
      in_valid = 0;
      in_last = $urandom_range(0, 1);
      @(negedge aclk);
    end
    in_data = w;
    in_valid = 1;
    in_last = $urandom_range(0, 1);
    forever begin
      logic rdy;
      rdy = in_ready;
      @(negedge aclk);
      if (rdy) break;
    end
    in_valid = 0;
  endtask

  task automatic send_frame(int gaps, int split_idle);
    for (int i = 0; i < NA + COLS; i++) begin
      if (i == 256 && split_idle > 0) repeat (split_idle) @(negedge aclk);
      put_word(words[i], gaps ? $urandom_range(0, 2) : 0);
    end
    in_last = 0;
  endtask

  task automatic drain(int stall, string tag);
    int got = 0;
    int waited = 0;
    while (got < ROWS && waited < 5000) begin
      logic [31:0] exp;
      exp = 0;
      for (int k = 0; k < COLS; k++) exp += a[got * COLS + k] * b[k];
      out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (out_valid) begin
        chk("R5 in_ready during output", {31'b0, in_ready}, 32'd0);
        if (out_ready) begin
          chk({"R4 R3 result ", tag}, out_data, exp);
          chk("R7 R6 out_last", {31'b0, out_last}, {31'b0, got == ROWS - 1});
          got++;
        end else begin
          logic [31:0] d;
          logic l;
          d = out_data; l = out_last;
          @(negedge aclk);
          chk("R8 valid held", {31'b0, out_valid}, 32'd1);
          chk("R8 data held", out_data, d);
          chk("R8 last held", {31'b0, out_last}, {31'b0, l});
          continue;
        end
      end
      @(negedge aclk);
      waited++;
    end
    out_ready = 0;
    chk("R6 beat count", got, ROWS);
    chk("R10 in_ready back", {31'b0, in_ready}, 32'd1);
    chk("R10 out_valid low", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge aclk);
    aresetn = 1;
    @(negedge aclk);
    chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 out_last", {31'b0, out_last}, 32'd0);

    make_frame(0); send_frame(0, 0);
    @(negedge aclk);
    chk("R5 in_ready after frame", {31'b0, in_ready}, 32'd0);
    drain(0, "max");

    make_frame(1); send_frame(1, 0); drain(1, "junk-bits R9 gaps R2");
    make_frame(3); send_frame(0, 300); drain(1, "R11 split");
    make_frame(2); send_frame(1, 0); drain(0, "zeros");
    make_frame(1); send_frame(1, 40); drain(1, "mixed");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule